// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit with Extension Word

This block is a 32-bit integer multiply and divide engine that owns one extra 32-bit word of state, called the extension word. The extension word holds the upper half of every 64-bit product and supplies the upper half of every 64-bit dividend. A divide leaves its remainder in the extension word. As a result, two divides issued one after the other form a 64-by-32 division, and a multiply followed by a divide computes (a*b)/c with the full 64-bit intermediate.

An operation starts with a one-cycle start strobe that carries an operation code, a destination operand and a source operand. Multiplies and divides iterate one bit per cycle. The unit reports busy while it works and raises done for a single cycle when the destination result and the extension word are updated. Condition flags report a zero result, a negative result, a quotient overflow and a division by zero. A load operation lets software preset or clear the extension word before a divide.

Operation codes on `op` are:
- 3'b000: unsigned multiply
- 3'b001: signed multiply
- 3'b010: unsigned divide
- 3'b011: signed divide
- 3'b100: extension-word load

All other codes are undefined.

Top module: `mdu_top`

## Requirements
- R1: Code 3'b000 forms the unsigned 64-bit product of dest_in and src_in. The low word goes to dest_out and the high word goes to mdr_out. The flags are set as follows: flag_zero when all 64 product bits are zero, flag_neg equal to product bit 63, and flag_ovf and flag_dz cleared.
- R2: Code 3'b001 does the same as R1, but the operands are treated as two's-complement numbers and the product is the signed 64-bit product.
- R3: Code 3'b010 divides the unsigned 64-bit value {mdr_out, dest_in} by src_in. The quotient goes to dest_out and the remainder goes to mdr_out. flag_zero is set when the quotient is zero, flag_neg equals quotient bit 31, and flag_ovf and flag_dz are cleared.
- R4: Code 3'b011 divides the two's-complement value {mdr_out, dest_in} by the signed src_in. The quotient is truncated toward zero, and a nonzero remainder carries the sign of the dividend. The flags follow R3.
- R5: Code 3'b100 copies src_in into mdr_out, sets dest_out to dest_in and leaves all four flags unchanged.
- R6: Operations chain through the extension word. A multiply followed by a divide yields the exact (a*b)/c. Two unsigned divides, the first issued after the extension word is cleared, give a 64-bit quotient and a 32-bit remainder.
- R7: A divide with src_in equal to zero sets flag_dz and clears the other flags. It sets dest_out to dest_in and leaves mdr_out unchanged.
- R8: A divide whose quotient does not fit in 32 bits sets flag_ovf and clears the other flags. dest_out becomes dest_in and mdr_out is unchanged. The unsigned case is mdr_out >= src_in. The signed case is a quotient outside -2^31..2^31-1.
- R9: A multiply or divide that iterates has busy high from the start edge onward. Its done is high during the 34th cycle counted from the start edge. Loads, zero divisors and divides whose dividend high-word magnitude is at least the divisor magnitude finish at the start edge itself, with done high in the next cycle. done lasts exactly one cycle and is never high together with busy.
- R10: A start strobe that arrives while busy is ignored. The running operation's results and the extension word are unaffected by it and by any change of the operand inputs after the start edge.
- R11: A start strobe with an undefined code is ignored: done is not raised, busy stays low, and the results and flags keep their values.
- R12: After reset, dest_out, mdr_out, all flags, busy and done are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request strobe |
| op | input | 3 | Operation code |
| dest_in | input | 32 | Destination operand (low dividend word, multiplicand) |
| src_in | input | 32 | Source operand (multiplier, divisor, load value) |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle completion pulse |
| dest_out | output | 32 | Destination result |
| mdr_out | output | 32 | Extension word contents |
| flag_zero | output | 1 | Result is zero |
| flag_neg | output | 1 | Result sign bit |
| flag_ovf | output | 1 | Quotient overflow |
| flag_dz | output | 1 | Division by zero |

## Verification
The remainder-bound property in the divider takes for granted that the divider core is loaded only with a nonzero divisor and a dividend whose upper half is already below it. The top module guarantees this by completing zero-divisor and too-large cases at the start edge. The assertions on the early-exit cases compare against the operands seen at the start edge and against the operation code of that edge. For this reason the stimulus holds op, dest_in and src_in stable only in the strobe cycle, and then deliberately changes them while the unit iterates. The stimulus also raises start during an active operation and with undefined codes, so that the ignore paths are reached without ever violating the assumption that start is a single-cycle pulse sampled away from the clock edge.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

    localparam int XLEN = 32;

    typedef enum logic [2:0] {
        OP_MULU  = 3'b000,
        OP_MULS  = 3'b001,
        OP_DIVU  = 3'b010,
        OP_DIVS  = 3'b011,
        OP_MDRLD = 3'b100
    } mdu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FIN
    } mdu_state_e;

    typedef struct packed {
        logic zero;
        logic neg;
        logic ovf;
        logic dz;
    } mdu_flags_t;

    function automatic logic op_is_div(mdu_op_e o);
        return (o == OP_DIVU) || (o == OP_DIVS);
    endfunction

    function automatic logic op_is_signed(mdu_op_e o);
        return (o == OP_MULS) || (o == OP_DIVS);
    endfunction

    function automatic logic op_is_known(mdu_op_e o);
        return (o == OP_MULU) || (o == OP_MULS) || (o == OP_DIVU) ||
               (o == OP_DIVS) || (o == OP_MDRLD);
    endfunction

    function automatic mdu_flags_t mk_flags(logic z, logic n, logic v, logic d);
        mdu_flags_t f;
        f.zero = z;
        f.neg  = n;
        f.ovf  = v;
        f.dz   = d;
        return f;
    endfunction

endpackage

// File: rtl/mdu_mul_core.sv
module mdu_mul_core #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           step,
    input  logic [W-1:0]   a_mag,
    input  logic [W-1:0]   b_mag,
    output logic [2*W-1:0] prod
);
    localparam int PW = 2 * W;

    logic [PW-1:0] acc_q;
    logic [PW-1:0] mcand_q;
    logic [W-1:0]  mplier_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q    <= '0;
            mcand_q  <= '0;
            mplier_q <= '0;
        end else if (load) begin
            acc_q    <= '0;
            mcand_q  <= {{W{1'b0}}, a_mag};
            mplier_q <= b_mag;
        end else if (step) begin
            if (mplier_q[0]) begin
                acc_q <= acc_q + mcand_q;
            end
            mcand_q  <= mcand_q << 1;
            mplier_q <= mplier_q >> 1;
        end
    end

    assign prod = acc_q;

endmodule

// File: rtl/mdu_div_core.sv
module mdu_div_core #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           step,
    input  logic [2*W-1:0] dividend,
    input  logic [W-1:0]   divisor,
    output logic [W-1:0]   quot,
    output logic [W-1:0]   rem
);
    logic [W-1:0] r_q;
    logic [W-1:0] q_q;
    logic [W-1:0] d_q;
    logic [W:0]   trial;
    logic [W:0]   diff;
    logic         take;

    always_comb begin
        trial = {r_q, q_q[W-1]};
        diff  = trial - {1'b0, d_q};
        take  = ~diff[W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
            q_q <= '0;
            d_q <= '0;
        end else if (load) begin
            r_q <= dividend[2*W-1:W];
            q_q <= dividend[W-1:0];
            d_q <= divisor;
        end else if (step) begin
            r_q <= take ? diff[W-1:0] : trial[W-1:0];
            q_q <= {q_q[W-2:0], take};
        end
    end

    assign quot = q_q;
    assign rem  = r_q;

    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (rst)
        step |-> (r_q < d_q)); // R3

endmodule

// File: rtl/mdu_top.sv
module mdu_top
    import mdu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [2:0]   op,
    input  logic [W-1:0] dest_in,
    input  logic [W-1:0] src_in,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] dest_out,
    output logic [W-1:0] mdr_out,
    output logic         flag_zero,
    output logic         flag_neg,
    output logic         flag_ovf,
    output logic         flag_dz
);
    localparam int PW = 2 * W;
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);
    localparam logic [W-1:0]  MIN_MAG   = {1'b1, {(W-1){1'b0}}};

    mdu_state_e state_q;
    logic [CW-1:0] cnt_q;
    logic [W-1:0]  mdr_q, dest_q, keep_q;
    mdu_flags_t    flags_q;
    logic          done_q, is_div_q, sgn_q, res_neg_q, rem_neg_q;

    mdu_op_e       op_e;
    logic          accept, sgn, a_neg, b_neg, dvd_neg;
    logic [W-1:0]  a_mag, b_mag;
    logic [PW-1:0] dvd, dvd_mag;
    logic          div_zero, div_big, mul_load, div_load, mul_step, div_step;
    logic [PW-1:0] mul_prod, prod_s;
    logic [W-1:0]  quot_m, rem_m, quot_s, rem_s;
    logic          quot_fits;

    always_comb begin
        op_e     = mdu_op_e'(op);
        accept   = start && (state_q == ST_IDLE) && op_is_known(op_e);
        sgn      = op_is_signed(op_e);
        a_neg    = sgn & dest_in[W-1];
        b_neg    = sgn & src_in[W-1];
        a_mag    = a_neg ? -dest_in : dest_in;
        b_mag    = b_neg ? -src_in : src_in;
        dvd      = {mdr_q, dest_in};
        dvd_neg  = sgn & mdr_q[W-1];
        dvd_mag  = dvd_neg ? -dvd : dvd;
        div_zero = (src_in == '0);
        div_big  = (dvd_mag[PW-1:W] >= b_mag);
        mul_load = accept && !op_is_div(op_e) && (op_e != OP_MDRLD);
        div_load = accept && op_is_div(op_e) && !div_zero && !div_big;
        mul_step = (state_q == ST_RUN) && !is_div_q;
        div_step = (state_q == ST_RUN) && is_div_q;
    end

    mdu_mul_core #(.W(W)) u_mul (
        .clk   (clk),
        .rst   (rst),
        .load  (mul_load),
        .step  (mul_step),
        .a_mag (a_mag),
        .b_mag (b_mag),
        .prod  (mul_prod)
    );

    mdu_div_core #(.W(W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .load     (div_load),
        .step     (div_step),
        .dividend (dvd_mag),
        .divisor  (b_mag),
        .quot     (quot_m),
        .rem      (rem_m)
    );

    always_comb begin
        prod_s    = res_neg_q ? -mul_prod : mul_prod;
        quot_s    = res_neg_q ? -quot_m : quot_m;
        rem_s     = rem_neg_q ? -rem_m : rem_m;
        quot_fits = !sgn_q || (res_neg_q ? (quot_m <= MIN_MAG) : (quot_m < MIN_MAG));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            mdr_q     <= '0;
            dest_q    <= '0;
            keep_q    <= '0;
            flags_q   <= '0;
            done_q    <= 1'b0;
            is_div_q  <= 1'b0;
            sgn_q     <= 1'b0;
            res_neg_q <= 1'b0;
            rem_neg_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (op_e == OP_MDRLD) begin
                            mdr_q  <= src_in;
                            dest_q <= dest_in;
                            done_q <= 1'b1;
                        end else if (op_is_div(op_e) && div_zero) begin
                            dest_q  <= dest_in;
                            flags_q <= mk_flags(1'b0, 1'b0, 1'b0, 1'b1);
                            done_q  <= 1'b1;
                        end else if (op_is_div(op_e) && div_big) begin
                            dest_q  <= dest_in;
                            flags_q <= mk_flags(1'b0, 1'b0, 1'b1, 1'b0);
                            done_q  <= 1'b1;
                        end else begin
                            state_q   <= ST_RUN;
                            cnt_q     <= '0;
                            is_div_q  <= op_is_div(op_e);
                            sgn_q     <= sgn;
                            res_neg_q <= op_is_div(op_e) ? (dvd_neg ^ b_neg) : (a_neg ^ b_neg);
                            rem_neg_q <= dvd_neg;
                            keep_q    <= dest_in;
                        end
                    end
                end
                ST_RUN: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST_STEP) begin
                        state_q <= ST_FIN;
                    end
                end
                ST_FIN: begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                    if (!is_div_q) begin
                        dest_q  <= prod_s[W-1:0];
                        mdr_q   <= prod_s[PW-1:W];
                        flags_q <= mk_flags(prod_s == '0, prod_s[PW-1], 1'b0, 1'b0);
                    end else if (quot_fits) begin
                        dest_q  <= quot_s;
                        mdr_q   <= rem_s;
                        flags_q <= mk_flags(quot_s == '0, quot_s[W-1], 1'b0, 1'b0);
                    end else begin
                        dest_q  <= keep_q;
                        flags_q <= mk_flags(1'b0, 1'b0, 1'b1, 1'b0);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state_q != ST_IDLE);
    assign done      = done_q;
    assign dest_out  = dest_q;
    assign mdr_out   = mdr_q;
    assign flag_zero = flags_q.zero;
    assign flag_neg  = flags_q.neg;
    assign flag_ovf  = flags_q.ovf;
    assign flag_dz   = flags_q.dz;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R9
    AST_HOLD_WHILE_RUN: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN) |=> ($stable(mdr_out) && $stable(dest_out))); // R10
    AST_DZ_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
        (done && flag_dz && ($past(op) != 3'b100)) |->
        ((dest_out == $past(dest_in)) && (mdr_out == $past(mdr_out)))); // R7
    AST_OVF_KEEPS_MDR: assert property (@(posedge clk) disable iff (rst)
        (done && flag_ovf && ($past(op) != 3'b100)) |-> (mdr_out == $past(mdr_out))); // R8
    AST_ERROR_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        (flag_ovf || flag_dz) |-> ($onehot0({flag_ovf, flag_dz}) && !flag_zero && !flag_neg)); // R8
    AST_UNDEF_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !op_is_known(op_e)) |=> (!done && !busy)); // R11

endmodule

// File: tb/mdu_top_bench.sv
`timescale 1ns/1ps
module mdu_top_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  op = 3'b000;
    logic [31:0] dest_in = '0;
    logic [31:0] src_in = '0;
    logic        busy, done, flag_zero, flag_neg, flag_ovf, flag_dz;
    logic [31:0] dest_out, mdr_out;

    mdu_top u_mdu_top (
        .clk(clk), .rst(rst), .start(start), .op(op),
        .dest_in(dest_in), .src_in(src_in),
        .busy(busy), .done(done), .dest_out(dest_out), .mdr_out(mdr_out),
        .flag_zero(flag_zero), .flag_neg(flag_neg),
        .flag_ovf(flag_ovf), .flag_dz(flag_dz)
    );

    always #2.5 clk = ~clk;

    int errors = 0;
    int checks = 0;
    logic [31:0] m_mdr = '0;
    logic [3:0]  m_flags = '0;

    function automatic logic [3:0] fl();
        return {flag_zero, flag_neg, flag_ovf, flag_dz};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] o, input logic [31:0] d, input logic [31:0] s,
                          input string tag);
        logic [31:0] e_dest, e_mdr;
        logic [3:0]  e_fl;
        int          e_lat, lat;
        logic        busy1;
        logic [63:0] p, ud, uq, ur, dm, vm;
        longint      sd, sv, q, r;
        e_dest = d; e_mdr = m_mdr; e_fl = m_flags; e_lat = 1;
        case (o)
            3'b000: begin
                p = {32'b0, d} * {32'b0, s};
                e_dest = p[31:0]; e_mdr = p[63:32];
                e_fl = {p == 64'd0, p[63], 2'b00}; e_lat = 34;
            end
            3'b001: begin
                sd = $signed(d); sv = $signed(s); p = sd * sv;
                e_dest = p[31:0]; e_mdr = p[63:32];
                e_fl = {p == 64'd0, p[63], 2'b00}; e_lat = 34;
            end
            3'b010: begin
                ud = {m_mdr, d};
                if (s == 0) e_fl = 4'b0001;
                else if (m_mdr >= s) e_fl = 4'b0010;
                else begin
                    uq = ud / {32'b0, s}; ur = ud % {32'b0, s};
                    e_dest = uq[31:0]; e_mdr = ur[31:0];
                    e_fl = {uq[31:0] == 0, uq[31], 2'b00}; e_lat = 34;
                end
            end
            3'b011: begin
                sd = $signed({m_mdr, d}); sv = $signed(s);
                dm = (sd < 0) ? 64'(-sd) : 64'(sd);
                vm = (sv < 0) ? 64'(-sv) : 64'(sv);
                if (s == 0) e_fl = 4'b0001;
                else if (dm[63:32] >= vm[31:0]) e_fl = 4'b0010;
                else begin
                    e_lat = 34;
                    q = sd / sv; r = sd % sv;
                    if (q > 64'sd2147483647 || q < -64'sd2147483648) e_fl = 4'b0010;
                    else begin
                        e_dest = q[31:0]; e_mdr = r[31:0];
                        e_fl = {q[31:0] == 0, q[31], 2'b00};
                    end
                end
            end
            default: e_mdr = s;
        endcase
        @(negedge clk);
        op = o; dest_in = d; src_in = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0; dest_in = ~d; src_in = ~s; op = 3'b111;
        lat = 1; busy1 = busy;
        while (!done && lat < 60) begin
            @(negedge clk);
            lat++;
        end
        chk({tag, " R9 latency"}, 64'(lat), 64'(e_lat));
        chk({tag, " R9 busy"}, {63'b0, busy1}, {63'b0, e_lat > 1});
        chk({tag, " dest"}, {32'b0, dest_out}, {32'b0, e_dest});
        chk({tag, " mdr"}, {32'b0, mdr_out}, {32'b0, e_mdr});
        chk({tag, " flags"}, {60'b0, fl()}, {60'b0, e_fl});
        @(negedge clk);
        chk({tag, " R9 done one cycle"}, {63'b0, done}, 64'd0);
        m_mdr = e_mdr; m_flags = e_fl;
    endtask

    task automatic t_reset();
        chk("R12 reset dest", {32'b0, dest_out}, 64'd0);
        chk("R12 reset mdr", {32'b0, mdr_out}, 64'd0);
        chk("R12 reset flags/busy/done", {58'b0, fl(), busy, done}, 64'd0);
    endtask

    task automatic t_mul_unsigned();
        run_op(3'b000, 32'h0, 32'h1234, "R1 zero product");
        run_op(3'b000, 32'hFFFFFFFF, 32'hFFFFFFFF, "R1 max*max");
        run_op(3'b000, 32'h12345678, 32'h9ABCDEF0, "R1 mixed");
    endtask

    task automatic t_mul_signed();
        run_op(3'b001, -32'sd3, 32'd7, "R2 neg*pos");
        run_op(3'b001, -32'sd5, -32'sd6, "R2 neg*neg");
        run_op(3'b001, 32'h80000000, 32'h80000000, "R2 min*min");
        run_op(3'b001, 32'h80000000, 32'd1, "R2 min*1");
    endtask

    task automatic t_div_unsigned();
        run_op(3'b100, 32'h0, 32'h0, "R5 clear");
        run_op(3'b010, 32'd100, 32'd7, "R3 small");
        run_op(3'b100, 32'h0, 32'd5, "R5 preset");
        run_op(3'b010, 32'h00001234, 32'h10, "R3 with high word");
        run_op(3'b100, 32'h0, 32'h7FFFFFFF, "R5 preset big");
        run_op(3'b010, 32'hABCDEF01, 32'hFFFFFFFF, "R3 max divisor");
    endtask

    task automatic t_div_signed();
        run_op(3'b100, 32'h0, 32'hFFFFFFFF, "R5 sign fill");
        run_op(3'b011, -32'sd100, 32'd7, "R4 neg/pos");
        run_op(3'b100, 32'h0, 32'h0, "R5 clear");
        run_op(3'b011, 32'd100, -32'sd7, "R4 pos/neg");
        run_op(3'b100, 32'h0, 32'hFFFFFFFF, "R5 sign fill");
        run_op(3'b011, -32'sd100, -32'sd7, "R4 neg/neg");
        run_op(3'b100, 32'h0, 32'hFFFFFFFF, "R5 sign fill");
        run_op(3'b011, 32'h80000000, 32'd1, "R4 min quotient fits");
    endtask

    task automatic t_chain();
        logic [31:0] qhi;
        logic [63:0] full;
        run_op(3'b000, 32'hDEADBEEF, 32'h00012345, "R6 mul step");
        run_op(3'b010, 32'hDEADBEEF, 32'h00010001, "R6 unsigned muldiv");
        run_op(3'b001, -32'sd1000000, 32'd3000000, "R6 signed mul step");
        run_op(3'b011, -32'sd1000000, 32'd7000, "R6 signed muldiv");
        run_op(3'b100, 32'h0, 32'h0, "R6 clear");
        run_op(3'b010, 32'h01234567, 32'h9876, "R6 high word");
        qhi = dest_out;
        run_op(3'b010, 32'h89ABCDEF, 32'h9876, "R6 low word");
        full = 64'h0123456789ABCDEF;
        chk("R6 64-bit quotient", {qhi, dest_out}, full / 64'h9876);
        chk("R6 64-bit remainder", {32'b0, mdr_out}, full % 64'h9876);
    endtask

    task automatic t_div_zero();
        run_op(3'b010, 32'h55, 32'h0, "R7 unsigned zero divisor");
        run_op(3'b100, 32'h1, 32'hCAFE, "R5 flags kept after dz");
        run_op(3'b011, 32'h66, 32'h0, "R7 signed zero divisor");
    endtask

    task automatic t_overflow();
        run_op(3'b100, 32'h0, 32'd10, "R5 preset");
        run_op(3'b010, 32'h0, 32'd10, "R8 unsigned high>=divisor");
        run_op(3'b100, 32'h0, 32'h0, "R5 clear");
        run_op(3'b011, 32'h80000000, 32'd1, "R8 signed quotient 2^31");
        run_op(3'b100, 32'h0, 32'hFFFFFFFF, "R5 sign fill");
        run_op(3'b011, 32'h80000000, 32'hFFFFFFFF, "R8 signed min/-1");
        run_op(3'b100, 32'h0, 32'h80000000, "R5 min high");
        run_op(3'b011, 32'h0, 32'hFFFFFFFF, "R8 signed early overflow");
    endtask

    task automatic t_busy_ignore();
        int lat;
        int extra;
        run_op(3'b100, 32'h0, 32'h0, "R10 clear");
        @(negedge clk);
        op = 3'b000; dest_in = 32'd7; src_in = 32'd9; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        op = 3'b100; dest_in = 32'hAAAA; src_in = 32'h12345678; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 60) begin
            @(negedge clk);
            lat++;
        end
        chk("R10 dest after ignored start", {32'b0, dest_out}, 64'd63);
        chk("R10 mdr after ignored start", {32'b0, mdr_out}, 64'd0);
        extra = 0;
        repeat (4) begin
            @(negedge clk);
            if (done) extra++;
        end
        chk("R10 no second completion", 64'(extra), 64'd0);
        m_mdr = 32'h0; m_flags = 4'b0000;
    endtask

    task automatic t_undef();
        int seen;
        @(negedge clk);
        op = 3'b110; dest_in = 32'h77; src_in = 32'h88; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        seen = 0;
        repeat (3) begin
            if (done || busy) seen++;
            @(negedge clk);
        end
        chk("R11 undefined code no activity", 64'(seen), 64'd0);
        chk("R11 undefined code mdr", {32'b0, mdr_out}, {32'b0, m_mdr});
        chk("R11 undefined code flags", {60'b0, fl()}, {60'b0, m_flags});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_mul_unsigned();
        t_mul_signed();
        t_div_unsigned();
        t_div_signed();
        t_chain();
        t_div_zero();
        t_overflow();
        t_busy_ignore();
        t_undef();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule